// File: doc/BRIEF.md
# Register Poison Tag Tracker

This block supports compiler-driven load speculation by holding one poison tag for each architectural register. A load that the compiler has hoisted above a branch is marked speculative. If such a load hits a fault, the pipeline does not trap at once. The writeback port reports the fault, and the block tags the destination register as poisoned. A later instruction that is not speculative may read a poisoned register. Only then does the block raise the deferred exception and name the register that carries it. A poisoned value that is overwritten, or never read, causes no exception at all.

A speculative instruction can read a poisoned source. It does not trap. Instead it passes the poison on to its own destination, so the fault follows the data until a committed consumer reads it. The block sees only register indices and flags. Memory access, the exception handler and data values stay outside it. The exception is presented one clock after the read that triggers it.

Top module: `poison_tracker`

## Requirements
- R1: After reset, every poison tag is clear and `excValid` is 0. Asserting reset again clears any tag that was set.
- R2: A writeback with `wbValid`=1, `wbSpec`=1 and `wbFault`=1 poisons register `wbDest`. The writeback itself raises no exception.
- R3: A read with `rdValid`=1 and `rdSpec`=0 whose source is poisoned sets `excValid`=1 on the next clock, with `excReg` equal to that source's index. A read with `rdValid`=0 never raises an exception.
- R4: A writeback with `wbFault`=0 clears the poison tag of `wbDest`, whether `wbSpec` is 0 or 1.
- R5: A writeback with `wbSpec`=0 and `wbFault`=1 is a precise fault handled elsewhere. It leaves the poison tag of `wbDest` unchanged.
- R6: A poisoned register that is never read by a committed instruction produces no exception. A read of clean sources, or any read with `rdSpec`=1, never sets `excValid`.
- R7: A read with `rdValid`=1 and `rdSpec`=1 that finds either source poisoned poisons register `rdDest` on the next clock and raises no exception.
- R8: If both sources of a committed read are poisoned, `excReg` reports source slot A (`rdSrcA`).
- R9: Register index 0 is hard-wired zero. It never becomes poisoned, by writeback or by propagation, and `excReg` is never 0 while `excValid` is 1.
- R10: When a writeback and a poison propagation target the same register in the same clock, the writeback decides that register's new tag.
- R11: A read sees the tags as they stood before any writeback in the same clock.
- R12: Reading a poisoned register, and raising its exception, leaves its tag set. A second committed read raises the exception again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wbValid | input | 1 | A writeback is presented this cycle |
| wbDest | input | IDX_W | Destination register of the writeback |
| wbSpec | input | 1 | The writing instruction was speculative |
| wbFault | input | 1 | The writing instruction hit a fault |
| rdValid | input | 1 | An instruction reads its sources this cycle |
| rdSpec | input | 1 | The reading instruction is speculative |
| rdSrcA | input | IDX_W | First source register index (slot A, reported first) |
| rdSrcB | input | IDX_W | Second source register index (slot B) |
| rdDest | input | IDX_W | Destination of the reader, poisoned when a speculative read propagates |
| excValid | output | 1 | Deferred exception raised, one clock after the read |
| excReg | output | IDX_W | Index of the poisoned register that raised it |

## Verification
Each scenario is driven with directed patterns that differ in the speculative and fault flags, so each combination of those two flags can be told apart. A committed read of a poisoned source must trap, a speculative read must propagate the poison, and a non-faulting write must clear it. The bench reads with both slots poisoned and swaps the two slots to show that slot A takes priority. Same-clock collisions check the ordering rules: a writeback against a propagation to the same register, and a writeback against a read of the same register. Register 0, a reset taken mid-run, and a committed fault on a clean register cover the corners where a tag must not change.

// File: rtl/poison_pkg.sv
package poison_pkg;

  // Strobes from the control path to the tag store.
  typedef struct packed {
    logic wrEn;   // writeback updates a tag
    logic wrSet;  // value written by writeback: 1 poison, 0 clean
    logic prEn;   // speculative read propagates poison
    logic excEn;  // committed read found poison
  } poison_strb_t;

endpackage

// File: rtl/poison_ctrl.sv
module poison_ctrl
  import poison_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             wbValid,
  input  logic [IDX_W-1:0] wbDest,
  input  logic             wbSpec,
  input  logic             wbFault,
  input  logic             rdValid,
  input  logic             rdSpec,
  input  logic [IDX_W-1:0] rdSrcA,
  input  logic [IDX_W-1:0] rdSrcB,
  input  logic [IDX_W-1:0] rdDest,
  input  logic             poisonA,
  input  logic             poisonB,
  output poison_strb_t     strb,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] prIdx,
  output logic [IDX_W-1:0] excIdx
);

  logic wbToZero;
  logic preciseFault;
  logic anyPoison;
  logic prToZero;

  always_comb begin
    wbToZero     = (wbDest == '0);
    preciseFault = wbFault && !wbSpec;
    anyPoison    = poisonA || poisonB;
    prToZero     = (rdDest == '0);

    strb.wrEn  = wbValid && !wbToZero && !preciseFault;
    strb.wrSet = wbSpec && wbFault;
    strb.prEn  = rdValid && rdSpec && anyPoison && !prToZero;
    strb.excEn = rdValid && !rdSpec && anyPoison;

    wrIdx  = wbDest;
    prIdx  = rdDest;
    excIdx = poisonA ? rdSrcA : rdSrcB;
  end

endmodule

// File: rtl/poison_store.sv
module poison_store
  import poison_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  poison_strb_t     strb,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [IDX_W-1:0] prIdx,
  input  logic [IDX_W-1:0] excIdx,
  input  logic [IDX_W-1:0] srcA,
  input  logic [IDX_W-1:0] srcB,
  output logic             poisonA,
  output logic             poisonB,
  output logic             excValid,
  output logic [IDX_W-1:0] excReg
);

  logic [NUM_REGS-1:0] tagVec;

  assign tagVec[0] = 1'b0;

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_tag
    logic tagQ;
    logic wrHit;
    logic prHit;
    assign wrHit = strb.wrEn && (wrIdx == IDX_W'(i));
    assign prHit = strb.prEn && (prIdx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tagQ <= 1'b0;
      else if (wrHit)  tagQ <= strb.wrSet;
      else if (prHit)  tagQ <= 1'b1;
    end
    assign tagVec[i] = tagQ;
  end

  assign poisonA = tagVec[srcA];
  assign poisonB = tagVec[srcB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      excValid <= 1'b0;
      excReg   <= '0;
    end else begin
      excValid <= strb.excEn;
      excReg   <= strb.excEn ? excIdx : '0;
    end
  end

endmodule

// File: rtl/poison_tracker.sv
module poison_tracker
  import poison_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wbValid,
  input  logic [IDX_W-1:0] wbDest,
  input  logic             wbSpec,
  input  logic             wbFault,
  input  logic             rdValid,
  input  logic             rdSpec,
  input  logic [IDX_W-1:0] rdSrcA,
  input  logic [IDX_W-1:0] rdSrcB,
  input  logic [IDX_W-1:0] rdDest,
  output logic             excValid,
  output logic [IDX_W-1:0] excReg
);

  poison_strb_t     strb;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] prIdx;
  logic [IDX_W-1:0] excIdx;
  logic             poisonA;
  logic             poisonB;

  poison_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .wbValid(wbValid), .wbDest(wbDest), .wbSpec(wbSpec), .wbFault(wbFault),
    .rdValid(rdValid), .rdSpec(rdSpec), .rdSrcA(rdSrcA), .rdSrcB(rdSrcB),
    .rdDest(rdDest), .poisonA(poisonA), .poisonB(poisonB),
    .strb(strb), .wrIdx(wrIdx), .prIdx(prIdx), .excIdx(excIdx)
  );

  poison_store #(.NUM_REGS(NUM_REGS)) u_store (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .wrIdx(wrIdx), .prIdx(prIdx), .excIdx(excIdx),
    .srcA(rdSrcA), .srcB(rdSrcB),
    .poisonA(poisonA), .poisonB(poisonB),
    .excValid(excValid), .excReg(excReg)
  );

endmodule

// File: rtl/poison_tracker_chk.sv
module poison_tracker_chk #(
  parameter int NUM_REGS = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rdValid,
  input logic             rdSpec,
  input logic [IDX_W-1:0] rdSrcA,
  input logic [IDX_W-1:0] rdSrcB,
  input logic             excValid,
  input logic [IDX_W-1:0] excReg
);

  // R1: no exception while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!excValid);
    end
  end

  // R3: an exception always follows a committed read one clock earlier
  p_exc_from_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    excValid |-> $past(rdValid && !rdSpec));

  // R3: the reported register is one of the sources of that read
  p_exc_src_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    excValid |-> (excReg == $past(rdSrcA) || excReg == $past(rdSrcB)));

  // R6: a speculative read never traps
  p_spec_read_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rdSpec) |-> !excValid);

  // R9: register 0 is never reported
  p_zero_never_r9: assert property (@(posedge clk) disable iff (!rst_n)
    excValid |-> (excReg != '0));

  // R8: slot A reported when both slots name reg 0 is impossible; slot A wins when sources are equal
  p_same_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (excValid && $past(rdSrcA) == $past(rdSrcB)) |-> (excReg == $past(rdSrcA)));

endmodule

bind poison_tracker poison_tracker_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdValid(rdValid), .rdSpec(rdSpec),
  .rdSrcA(rdSrcA), .rdSrcB(rdSrcB), .excValid(excValid), .excReg(excReg)
);

// File: tb/sim_poison_tracker.sv
`timescale 1ns/1ps
module sim_poison_tracker;

  localparam int NUM_REGS = 32;
  localparam int IDX_W = $clog2(NUM_REGS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wbValid = 1'b0;
  logic [IDX_W-1:0] wbDest = '0;
  logic             wbSpec = 1'b0;
  logic             wbFault = 1'b0;
  logic             rdValid = 1'b0;
  logic             rdSpec = 1'b0;
  logic [IDX_W-1:0] rdSrcA = '0;
  logic [IDX_W-1:0] rdSrcB = '0;
  logic [IDX_W-1:0] rdDest = '0;
  logic             excValid;
  logic [IDX_W-1:0] excReg;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  poison_tracker #(.NUM_REGS(NUM_REGS)) u0 (
    .clk(clk), .rst_n(rst_n), .wbValid(wbValid), .wbDest(wbDest),
    .wbSpec(wbSpec), .wbFault(wbFault), .rdValid(rdValid), .rdSpec(rdSpec),
    .rdSrcA(rdSrcA), .rdSrcB(rdSrcB), .rdDest(rdDest),
    .excValid(excValid), .excReg(excReg)
  );

  logic             gotV;
  logic [IDX_W-1:0] gotR;

  // One clock: drive at a falling edge, sample at the next falling edge.
  task automatic step(input logic wv, input int wd, input logic ws, input logic wf,
                      input logic rv, input logic rs, input int ra, input int rb,
                      input int rd);
    wbValid = wv; wbDest = IDX_W'(wd); wbSpec = ws; wbFault = wf;
    rdValid = rv; rdSpec = rs; rdSrcA = IDX_W'(ra); rdSrcB = IDX_W'(rb);
    rdDest = IDX_W'(rd);
    @(negedge clk);
    gotV = excValid;
    gotR = excReg;
    wbValid = 1'b0; rdValid = 1'b0; wbSpec = 1'b0; wbFault = 1'b0; rdSpec = 1'b0;
  endtask

  task automatic check(input string req, input logic expV, input int expR);
    testsRun++;
    if (gotV !== expV || (expV && gotR !== IDX_W'(expR))) begin
      testsFailed++;
      $display("FAIL %s: excValid=%0b excReg=%0d expected excValid=%0b excReg=%0d",
               req, gotV, gotR, expV, expR);
    end
  endtask

  task automatic wr(input int d, input logic s, input logic f);
    step(1'b1, d, s, f, 1'b0, 1'b0, 0, 0, 0);
  endtask

  task automatic rdCommit(input int a, input int b);
    step(1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b0, a, b, 0);
  endtask

  task automatic t_reset();
    gotV = excValid; gotR = excReg;
    check("R1 idle after reset", 1'b0, 0);
    rdCommit(5, 6);
    check("R1 tags clear after reset", 1'b0, 0);
  endtask

  task automatic t_defer();
    wr(5, 1'b1, 1'b1);
    check("R2 speculative fault does not trap", 1'b0, 0);
    rdCommit(5, 0);
    check("R3 committed read of poisoned reg", 1'b1, 5);
    rdCommit(0, 5);
    check("R12 poison persists after trap", 1'b1, 5);
    step(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 5, 5, 0);
    check("R3 no read valid, no trap", 1'b0, 0);
  endtask

  task automatic t_propagate();
    step(1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b1, 5, 0, 9);
    check("R6 speculative read does not trap", 1'b0, 0);
    rdCommit(9, 0);
    check("R7 poison propagated to dest", 1'b1, 9);
  endtask

  task automatic t_clear();
    wr(5, 1'b0, 1'b0);
    rdCommit(5, 0);
    check("R4 committed clean write clears", 1'b0, 0);
    wr(9, 1'b1, 1'b0);
    rdCommit(9, 0);
    check("R4 speculative clean write clears", 1'b0, 0);
  endtask

  task automatic t_precise();
    wr(7, 1'b1, 1'b1);
    wr(7, 1'b0, 1'b1);
    rdCommit(7, 0);
    check("R5 precise fault keeps poison", 1'b1, 7);
    wr(8, 1'b0, 1'b1);
    rdCommit(8, 0);
    check("R5 precise fault keeps clean", 1'b0, 0);
  endtask

  task automatic t_both();
    wr(12, 1'b1, 1'b1);
    wr(3, 1'b1, 1'b1);
    rdCommit(12, 3);
    check("R8 both poisoned reports slot A", 1'b1, 12);
    rdCommit(3, 12);
    check("R8 swapped slots report slot A", 1'b1, 3);
    rdCommit(4, 3);
    check("R3 only slot B poisoned", 1'b1, 3);
  endtask

  task automatic t_zero();
    wr(0, 1'b1, 1'b1);
    rdCommit(0, 0);
    check("R9 reg0 ignores poisoned write", 1'b0, 0);
    step(1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b1, 7, 0, 0);
    rdCommit(0, 0);
    check("R9 reg0 ignores propagation", 1'b0, 0);
  endtask

  task automatic t_collide();
    step(1'b1, 20, 1'b0, 1'b0, 1'b1, 1'b1, 7, 0, 20);
    rdCommit(20, 0);
    check("R10 writeback wins over propagation", 1'b0, 0);
    step(1'b1, 7, 1'b0, 1'b0, 1'b1, 1'b0, 7, 0, 0);
    check("R11 read sees tag before same-clock write", 1'b1, 7);
    rdCommit(7, 0);
    check("R11 write took effect after", 1'b0, 0);
  endtask

  task automatic t_unused();
    wr(14, 1'b1, 1'b1);
    check("R6 poisoning write no trap", 1'b0, 0);
    wr(14, 1'b0, 1'b0);
    check("R6 overwrite no trap", 1'b0, 0);
    rdCommit(14, 13);
    check("R6 unused poison never traps", 1'b0, 0);
  endtask

  task automatic t_rereset();
    wr(15, 1'b1, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rdCommit(15, 0);
    check("R1 reset clears set tag", 1'b0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_defer();
    t_propagate();
    t_clear();
    t_precise();
    t_both();
    t_zero();
    t_collide();
    t_unused();
    t_rereset();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule